// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether a received Ethernet frame is kept or dropped, using only its 48-bit destination address. The address is offered on a single cycle with a valid strobe. The verdict appears on the next cycle as an accept flag and a two-bit reason code.

Acceptance can come from three sources:
- A small bank of exact-match entries. A runtime count divides this bank into a unicast part and a multicast part.
- A 64-bin multicast hash table, indexed by a 6-bit XOR fold of the address.
- A promiscuous mode that keeps every frame.

All of these are loaded through a simple 32-bit register write port. Setting every hash bin gives all-multicast behaviour. Broadcast is treated as an ordinary multicast address and goes through the hash table.

Address byte k of the destination (byte 0 is the first octet on the wire) is carried on `da_addr[8k+7:8k]`. Bit 0 of byte 0 is therefore `da_addr[0]`.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, the outputs are low and the reason is reject (00). All entries, both hash words and the promiscuous bit are cleared, and the unicast count is 1.
- R2: A strobe on `da_valid` at a clock edge gives `dec_valid` high for exactly the following cycle. With no strobe, `dec_valid`, `dec_accept` and `dec_reason` are all zero.
- R3: Write register map, selected by `cfg_addr`:
  - 0x00 is the mode register: bit 0 is promiscuous, bits 11:8 are the unicast count.
  - 0x02 holds hash bins 0..31, with bin b at bit b.
  - 0x03 holds bins 32..63, with bin b at bit b-32.
  - Entry e sits at 0x10+2e and 0x11+2e. Its low word holds address bytes 3,2,1,0 in bits 31:24, 23:16, 15:8 and 7:0. Its high word holds byte 5 in bits 15:8 and byte 4 in bits 7:0.
  - Writes to any other address change nothing.
- R4: With a unicast count N, entries 0..N-1 are unicast entries and entries N..7 are multicast entries. A mode write whose count field exceeds 8 leaves the count unchanged, while the promiscuous bit is still updated.
- R5: A frame is multicast when `da_addr[0]` is 1, and unicast otherwise. An exact match counts only if the matching entry lies in the part of the bank that agrees with the frame type.
- R6: The hash bin is built by walking address bits from byte 0 to byte 5, and from bit 0 to bit 7 inside each byte. The k-th bit visited (k = 0..47) is XORed into bin bit k mod 6.
- R7: A multicast frame whose hash bin is set is accepted. A unicast frame is never accepted through the hash table.
- R8: With the promiscuous bit set, every frame is accepted.
- R9: The reason code is chosen in priority order: exact match 01, then hash 10, then promiscuous 11, otherwise reject 00. `dec_accept` is high exactly when the reason is not 00.
- R10: A register write on the same edge as an address strobe does not affect that frame's verdict; the frame is judged with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Verdict valid, one cycle after the strobe |
| dec_accept | output | 1 | Frame is kept |
| dec_reason | output | 2 | 00 reject, 01 exact, 10 hash, 11 promiscuous |

## Verification
The assertions check these properties on every cycle:
- the one-cycle strobe-to-verdict timing;
- that accept agrees with the reason code;
- that promiscuous mode always accepts;
- that unicast frames never carry the hash reason;
- that an oversize count write leaves the split point alone.

Some behaviours can only be shown by the bench's scenarios:
- the bit order of the XOR fold;
- the byte packing of the entry words;
- the effect of moving the unicast/multicast split over an entry;
- the priority between exact, hash and promiscuous;
- the use of old settings when a write coincides with a lookup.

For these scenarios, a behavioural model is compared against the outputs on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      RSN_REJECT  = 2'b00,
      RSN_EXACT   = 2'b01,
      RSN_HASH    = 2'b10,
      RSN_PROMISC = 2'b11
   } rsn_e;

   // register word addresses
   localparam int REG_MODE       = 0;
   localparam int REG_HASH_LO    = 2;
   localparam int REG_HASH_HI    = 3;
   localparam int REG_ENTRY_BASE = 16;

   // mode register fields
   localparam int MODE_PROMISC_BIT = 0;
   localparam int MODE_CNT_LSB     = 8;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
   import rxf_pkg::*;
#(
   parameter int N_ENTRIES   = 8,
   parameter int MAC_W       = 48,
   parameter int DATA_W      = 32,
   parameter int CFG_AW      = 5,
   parameter int BINS        = 64,
   parameter int CNT_W       = 4,
   parameter int RESET_UCAST = 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [CFG_AW-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [N_ENTRIES-1:0][MAC_W-1:0]   entries,
   output logic [BINS-1:0]                   hash_tbl,
   output logic                              promisc,
   output logic [CNT_W-1:0]                  ucnt
);

   localparam int HI_W = MAC_W - DATA_W;

   logic             sel_mode;
   logic             sel_hlo;
   logic             sel_hhi;
   logic [CNT_W-1:0] new_cnt;
   logic             cnt_ok;

   assign sel_mode = wr_en && (wr_addr == CFG_AW'(REG_MODE));
   assign sel_hlo  = wr_en && (wr_addr == CFG_AW'(REG_HASH_LO));
   assign sel_hhi  = wr_en && (wr_addr == CFG_AW'(REG_HASH_HI));
   assign new_cnt  = wr_data[MODE_CNT_LSB +: CNT_W];
   assign cnt_ok   = (new_cnt <= CNT_W'(N_ENTRIES));

   // mode register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         promisc <= 1'b0;
         ucnt    <= CNT_W'(RESET_UCAST);
      end else if (sel_mode) begin
         promisc <= wr_data[MODE_PROMISC_BIT];
         if (cnt_ok) begin
            ucnt <= new_cnt;
         end
      end
   end

   // hash table words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hash_tbl <= '0;
      end else begin
         if (sel_hlo) begin
            hash_tbl[DATA_W-1:0] <= wr_data;
         end
         if (sel_hhi) begin
            hash_tbl[BINS-1:DATA_W] <= wr_data;
         end
      end
   end

   // exact-match entries, two words each
   for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
      localparam int LO_A = REG_ENTRY_BASE + 2 * e;
      localparam int HI_A = LO_A + 1;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entries[e] <= '0;
         end else if (wr_en) begin
            if (wr_addr == CFG_AW'(LO_A)) begin
               entries[e][DATA_W-1:0] <= wr_data;
            end
            if (wr_addr == CFG_AW'(HI_A)) begin
               entries[e][MAC_W-1:DATA_W] <= wr_data[HI_W-1:0];
            end
         end
      end
   end

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_mode && !cnt_ok) |=> $stable(ucnt));

   // R3
   hash_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_hlo |=> (hash_tbl[DATA_W-1:0] == $past(wr_data)));

endmodule

// File: rtl/rxf_hash_fold.sv
module rxf_hash_fold #(
   parameter int MAC_W  = 48,
   parameter int HASH_W = 6
) (
   input  logic [MAC_W-1:0]  mac,
   output logic [HASH_W-1:0] idx
);

   // selects the address bits that land on one bin bit
   function automatic logic [MAC_W-1:0] fold_mask(input int pos);
      logic [MAC_W-1:0] m;
      m = '0;
      for (int k = 0; k < MAC_W; k++) begin
         m[k] = ((k % HASH_W) == pos);
      end
      return m;
   endfunction

   for (genvar h = 0; h < HASH_W; h++) begin : g_bit
      localparam logic [MAC_W-1:0] MASK = fold_mask(h);
      assign idx[h] = ^(mac & MASK);
   end

endmodule

// File: rtl/rxf_exact_bank.sv
module rxf_exact_bank #(
   parameter int N_ENTRIES = 8,
   parameter int MAC_W     = 48,
   parameter int CNT_W     = 4
) (
   input  logic [MAC_W-1:0]                 mac,
   input  logic [N_ENTRIES-1:0][MAC_W-1:0]  entries,
   input  logic [CNT_W-1:0]                 ucnt,
   output logic                             uc_hit,
   output logic                             mc_hit
);

   logic [N_ENTRIES-1:0] eq;
   logic [N_ENTRIES-1:0] uc_side;

   for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
      assign eq[e]      = (mac == entries[e]);
      assign uc_side[e] = (CNT_W'(e) < ucnt);
   end

   assign uc_hit = |(eq & uc_side);
   assign mc_hit = |(eq & ~uc_side);

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
   import rxf_pkg::*;
#(
   parameter int N_ENTRIES   = 8,
   parameter int MAC_W       = 48,
   parameter int DATA_W      = 32,
   parameter int CFG_AW      = 5,
   parameter int HASH_W      = 6,
   parameter int RESET_UCAST = 1,
   parameter bit HASH_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [4:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              da_valid,
   input  logic [47:0]       da_addr,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [1:0]        dec_reason
);

   localparam int CNT_W = $clog2(N_ENTRIES + 1);
   localparam int BINS  = 1 << HASH_W;

   // elaboration-time parameter checks
   if (N_ENTRIES < 1 || REG_ENTRY_BASE + 2 * N_ENTRIES > (1 << CFG_AW)) begin : g_bad_entries
      $error("rx_dest_filter: N_ENTRIES does not fit the register map");
   end
   if (BINS != 2 * DATA_W) begin : g_bad_bins
      $error("rx_dest_filter: hash table must span two data words");
   end
   if (MAC_W <= DATA_W || MAC_W > 2 * DATA_W) begin : g_bad_mac
      $error("rx_dest_filter: address must span one to two data words");
   end
   if (RESET_UCAST > N_ENTRIES) begin : g_bad_reset
      $error("rx_dest_filter: reset unicast count too large");
   end
   if (MODE_CNT_LSB + CNT_W > DATA_W) begin : g_bad_mode
      $error("rx_dest_filter: count field outside mode word");
   end
   if (CFG_AW != 5 || DATA_W != 32 || MAC_W != 48) begin : g_bad_ports
      $error("rx_dest_filter: port widths are fixed at 5/32/48");
   end

   logic [N_ENTRIES-1:0][MAC_W-1:0] entries;
   logic [BINS-1:0]                 hash_tbl;
   logic                            promisc;
   logic [CNT_W-1:0]                ucnt;
   logic                            uc_hit;
   logic                            mc_hit;
   logic [HASH_W-1:0]               hidx;
   logic                            hash_hit;
   logic                            is_mc;
   logic                            exact_hit;
   rsn_e                            rsn;

   rxf_cfg_regs #(
      .N_ENTRIES   (N_ENTRIES),
      .MAC_W       (MAC_W),
      .DATA_W      (DATA_W),
      .CFG_AW      (CFG_AW),
      .BINS        (BINS),
      .CNT_W       (CNT_W),
      .RESET_UCAST (RESET_UCAST)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .entries  (entries),
      .hash_tbl (hash_tbl),
      .promisc  (promisc),
      .ucnt     (ucnt)
   );

   rxf_exact_bank #(
      .N_ENTRIES (N_ENTRIES),
      .MAC_W     (MAC_W),
      .CNT_W     (CNT_W)
   ) u_bank (
      .mac     (da_addr),
      .entries (entries),
      .ucnt    (ucnt),
      .uc_hit  (uc_hit),
      .mc_hit  (mc_hit)
   );

   if (HASH_EN) begin : g_hash
      rxf_hash_fold #(
         .MAC_W  (MAC_W),
         .HASH_W (HASH_W)
      ) u_fold (
         .mac (da_addr),
         .idx (hidx)
      );
      assign hash_hit = da_addr[0] & hash_tbl[hidx];
   end else begin : g_nohash
      assign hidx     = '0;
      assign hash_hit = 1'b0;
   end

   always_comb begin
      is_mc     = da_addr[0];
      exact_hit = is_mc ? mc_hit : uc_hit;
      if (exact_hit) begin
         rsn = RSN_EXACT;
      end else if (hash_hit) begin
         rsn = RSN_HASH;
      end else if (promisc) begin
         rsn = RSN_PROMISC;
      end else begin
         rsn = RSN_REJECT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_reason <= RSN_REJECT;
      end else begin
         dec_valid  <= da_valid;
         dec_accept <= da_valid && (rsn != RSN_REJECT);
         dec_reason <= da_valid ? rsn : RSN_REJECT;
      end
   end

   // R2
   verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> dec_valid);

   // R2
   no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> (!dec_valid && !dec_accept && dec_reason == 2'b00));

   // R9
   accept_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_accept == (dec_reason != 2'b00)));

   // R8
   promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && promisc) |=> dec_accept);

   // R7
   ucast_no_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !da_addr[0]) |=> (dec_reason != 2'b10));

   // R5
   ucast_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !da_addr[0] && !uc_hit && !promisc) |=> !dec_accept);

endmodule

// File: tb/sim_rx_dest_filter.sv
module sim_rx_dest_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        da_valid = 1'b0;
   logic [47:0] da_addr = '0;
   logic        dec_valid;
   logic        dec_accept;
   logic [1:0]  dec_reason;

   int n_chk = 0;
   int n_err = 0;
   string cur_req = "R2";

   always #2 clk = ~clk;

   rx_dest_filter u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .da_valid   (da_valid),
      .da_addr    (da_addr),
      .dec_valid  (dec_valid),
      .dec_accept (dec_accept),
      .dec_reason (dec_reason)
   );

   // ---------------- behavioural reference model ----------------
   logic [47:0] m_ent [8];
   logic [63:0] m_hash;
   logic        m_prom;
   int          m_ucnt;
   logic        e_valid, e_acc;
   logic [1:0]  e_rsn;

   function automatic int ref_hash(input logic [47:0] a);
      int h = 0;
      int i = 0;
      for (int octet = 0; octet < 6; octet++) begin
         for (int b = 0; b < 8; b++) begin
            if (a[octet*8 + b]) h = h ^ (1 << i);
            i = (i == 5) ? 0 : i + 1;
         end
      end
      return h;
   endfunction

   function automatic logic [1:0] ref_decide(input logic [47:0] a);
      bit mc = a[0];
      bit ex = 0;
      for (int e = 0; e < 8; e++) begin
         if (m_ent[e] == a && ((e < m_ucnt) != mc)) ex = 1;
      end
      if (ex) return 2'b01;
      if (mc && m_hash[ref_hash(a)]) return 2'b10;
      if (m_prom) return 2'b11;
      return 2'b00;
   endfunction

   task automatic model_write(input logic [4:0] a, input logic [31:0] d);
      if (a == 5'd0) begin
         m_prom = d[0];
         if (d[11:8] <= 4'd8) m_ucnt = int'(d[11:8]);
      end else if (a == 5'd2) begin
         m_hash[31:0] = d;
      end else if (a == 5'd3) begin
         m_hash[63:32] = d;
      end else if (a >= 5'd16) begin
         if (a[0] == 1'b0) m_ent[(a - 16) / 2][31:0] = d;
         else m_ent[(a - 16) / 2][47:32] = d[15:0];
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < 8; e++) m_ent[e] = '0;
         m_hash = '0;
         m_prom = 1'b0;
         m_ucnt = 1;
         e_valid = 1'b0;
         e_acc = 1'b0;
         e_rsn = 2'b00;
      end else begin
         e_valid = da_valid;
         e_rsn = da_valid ? ref_decide(da_addr) : 2'b00;
         e_acc = da_valid && (e_rsn != 2'b00);
         if (cfg_we) model_write(cfg_addr, cfg_wdata);
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // every-clock comparison against the model (R2, R9 and whatever cur_req names)
   always @(negedge clk) begin
      if (rst_n) begin
         chk({29'd0, dec_valid, dec_accept}, {29'd0, e_valid, e_acc}, cur_req, "model valid/accept");
         chk({30'd0, dec_reason}, {30'd0, e_rsn}, cur_req, "model reason");
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(input bit we, input logic [4:0] wa, input logic [31:0] wd,
                       input bit dv, input logic [47:0] da);
      cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
      da_valid = dv; da_addr = da;
      @(negedge clk);
      cfg_we = 1'b0; da_valid = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0, '0);
   endtask

   task automatic set_entry(input int e, input logic [47:0] mac);
      wr(5'(16 + 2*e), mac[31:0]);
      wr(5'(17 + 2*e), {16'd0, mac[47:32]});
   endtask

   task automatic look(input logic [47:0] mac, input bit acc, input logic [1:0] rsn,
                       input string req);
      cur_req = req;
      step(1'b0, '0, '0, 1'b1, mac);
      chk({31'd0, dec_valid}, 32'd1, req, "valid");
      chk({31'd0, dec_accept}, {31'd0, acc}, req, "accept");
      chk({30'd0, dec_reason}, {30'd0, rsn}, req, "reason");
   endtask

   // ---------------- scenarios ----------------
   localparam logic [47:0] STA = 48'h5544_3322_1100;
   localparam logic [47:0] UC2 = 48'hA0B0_C0D0_E0F2;
   localparam logic [47:0] UC3 = 48'h1234_5678_9ABC;
   localparam logic [47:0] MC1 = 48'h6655_4433_2201;
   localparam logic [47:0] UCX = 48'h0F0E_0D0C_0B0A;

   initial begin : main
      logic [47:0] mlo, mhi, a;
      int blo, bhi;
      blo = -1; bhi = -1; mlo = '0; mhi = '0;

      repeat (3) @(negedge clk);
      // R1 reset state seen at the ports
      chk({29'd0, dec_valid, dec_accept}, 32'd0, "R1", "outputs in reset");
      chk({30'd0, dec_reason}, 32'd0, "R1", "reason in reset");
      rst_n = 1'b1;
      @(negedge clk);
      // R1: cleared entry 0 is unicast (count 1), hash empty
      look(48'h0, 1'b1, 2'b01, "R1");
      look(48'h1, 1'b0, 2'b00, "R1");

      // R3 packing of an entry
      set_entry(0, STA);
      look(STA, 1'b1, 2'b01, "R3");
      look(STA ^ 48'h0000_0000_0100, 1'b0, 2'b00, "R3");
      wr(5'd1, 32'hFFFF_FFFF);          // unmapped address
      wr(5'd4, 32'hFFFF_FFFF);
      look(MC1, 1'b0, 2'b00, "R3");

      // R4 / R5 split point
      wr(5'd0, 32'h0000_0300);
      set_entry(2, MC1);
      look(MC1, 1'b0, 2'b00, "R4");
      wr(5'd0, 32'h0000_0200);
      look(MC1, 1'b1, 2'b01, "R4");
      set_entry(6, UC2);
      look(UC2, 1'b0, 2'b00, "R5");
      set_entry(1, UC3);
      look(UC3, 1'b1, 2'b01, "R5");
      wr(5'd0, 32'h0000_0900);          // oversize count ignored
      look(MC1, 1'b1, 2'b01, "R4");
      look(UC3, 1'b1, 2'b01, "R4");
      wr(5'd0, 32'h0000_0000);          // no unicast entries
      look(STA, 1'b0, 2'b00, "R4");
      look(MC1, 1'b1, 2'b01, "R4");
      wr(5'd0, 32'h0000_0200);

      // R6 fold bit order: bits 0 and 47 -> bin 33, bits 0 and 6 -> bin 0
      wr(5'd3, 32'h0000_0002);
      look(48'h8000_0000_0001, 1'b1, 2'b10, "R6");
      look(48'h0000_0000_0041, 1'b0, 2'b00, "R6");
      wr(5'd3, 32'h0000_0000);
      wr(5'd2, 32'h0000_0001);          // broadcast folds to bin 0
      look(48'hFFFF_FFFF_FFFF, 1'b1, 2'b10, "R6");
      wr(5'd2, 32'h0000_0000);
      look(48'hFFFF_FFFF_FFFF, 1'b0, 2'b00, "R6");

      // R7 hash table halves
      for (int v = 0; v < 256; v++) begin
         a = {8'(v), 40'h00_4433_2201};
         if (ref_hash(a) < 32 && blo < 0) begin blo = ref_hash(a); mlo = a; end
         if (ref_hash(a) >= 32 && bhi < 0) begin bhi = ref_hash(a); mhi = a; end
      end
      wr(5'd2, 32'd1 << blo);
      look(mlo, 1'b1, 2'b10, "R7");
      look(mhi, 1'b0, 2'b00, "R7");
      wr(5'd3, 32'd1 << (bhi - 32));
      look(mhi, 1'b1, 2'b10, "R7");
      look(mlo ^ 48'h41, 1'b0, 2'b00, "R7");   // same bin, unicast
      wr(5'd2, 32'hFFFF_FFFF);                  // all-multicast
      wr(5'd3, 32'hFFFF_FFFF);
      look(48'h0102_0304_0507, 1'b1, 2'b10, "R7");
      look(UCX, 1'b0, 2'b00, "R7");

      // R8 / R9 promiscuous and priority
      wr(5'd0, 32'h0000_0201);
      look(UCX, 1'b1, 2'b11, "R8");
      look(STA, 1'b1, 2'b01, "R9");
      look(48'h0102_0304_0507, 1'b1, 2'b10, "R9");
      look(MC1, 1'b1, 2'b01, "R9");
      wr(5'd2, 32'h0); wr(5'd3, 32'h0);
      look(48'h0102_0304_0507, 1'b1, 2'b11, "R8");

      // R10 write coincides with lookup
      cur_req = "R10";
      step(1'b1, 5'd0, 32'h0000_0200, 1'b1, UCX);
      chk({31'd0, dec_accept}, 32'd1, "R10", "old promisc used");
      chk({30'd0, dec_reason}, 32'd3, "R10", "old reason");
      look(UCX, 1'b0, 2'b00, "R10");

      // R2 back-to-back random traffic against the model
      cur_req = "R2";
      wr(5'd2, 32'h5A5A_0F0F); wr(5'd3, 32'h0F0F_A5A5);
      for (int n = 0; n < 400; n++) begin
         logic [47:0] r;
         r = {$urandom, $urandom} ;
         case (n % 5)
            0: r = STA;
            1: r = MC1;
            default: ;
         endcase
         if (n % 37 == 0) begin
            step(1'b1, 5'd0, {20'd0, 4'($urandom_range(0, 10)), 7'd0, 1'($urandom)},
                 ($urandom % 2) == 1, r);
         end else begin
            step(1'b0, '0, '0, ($urandom % 4) != 0, r);
         end
      end
      repeat (2) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule